// File: doc/BRIEF.md
# Video controller command port decoder

This block sits behind the 16-bit control port of a video controller and sorts each written word into one of three kinds. A word whose two top bits are `10`, written while no command is half-done, is a register write: bits 12:8 pick the register and bits 7:0 carry the value. Any other word, written while no command is half-done, is the first half of a two-word command. The next control-port write is always the second half.

The two halves carry a 6-bit access code, a 16-bit target address and a request to start a transfer. The access code picks the target memory and the operation. The block stores the registers that a transfer engine needs: the address step, the transfer length and the source address with its mode bits. It also sends that engine a one-clock start pulse.

The data port is not decoded here. The block only sees that the data port was accessed, and that access abandons a half-written command.

Top module: `vcp_cmd_decoder`

## Requirements
- R1: While reset is held (rst_n low) and after it is released, the outputs read as follows: cmd_pending, dma_start, acc_code, target_addr, addr_step, xfer_len, xfer_src and xfer_mode are all zero.
- R2: A control write with bits 15:14 = `10` while cmd_pending is low is a register write. Bits 12:8 give the index and bits 7:0 give the value. The write is visible at the outputs after the clock edge that takes it.
- R3: A register write to an index other than 0x0F, 0x13, 0x14, 0x15, 0x16 or 0x17 changes no output.
- R4: A control write while cmd_pending is low, with bits 15:14 not `10`, is a first command word. It sets cmd_pending, loads acc_code[1:0] from bits 15:14 and loads target_addr[13:0] from bits 13:0. acc_code[5:2] and target_addr[15:14] keep their values.
- R5: A control write while cmd_pending is high is a second command word, whatever its top bits. It loads acc_code[5:2] from bits 7:4 and target_addr[15:14] from bits 1:0, and it clears cmd_pending. It never writes a register.
- R6: dma_start is high for exactly one clock, in the cycle after a second command word that has bit 7 set. It is low at all other times.
- R7: xfer_mode is decoded from bits 7:6 of register 0x17. `0x` gives 00 (copy from the host bus), `10` gives 10 (fill) and `11` gives 11 (video RAM to video RAM copy).
- R8: A data-port access clears cmd_pending, so the next control write is decoded as a register write or as a first command word. The access leaves acc_code and target_addr unchanged.
- R9: xfer_len is {reg 0x14, reg 0x13}. xfer_src is {reg 0x17 bits 6:0, reg 0x16, reg 0x15}.
- R10: addr_step shows register 0x0F.

Ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-port write strobe, one word per cycle |
| ctl_data | input | 16 | Control-port write data |
| dat_acc | input | 1 | Data-port access strobe (read or write) |
| cmd_pending | output | 1 | First command word taken, second word awaited |
| acc_code | output | 6 | Latched access code |
| target_addr | output | 16 | Latched target address |
| dma_start | output | 1 | One-clock transfer start request |
| addr_step | output | 8 | Address increment applied after each transfer |
| xfer_len | output | 16 | Transfer length in words |
| xfer_src | output | 23 | Transfer source address field |
| xfer_mode | output | 2 | Decoded transfer mode |

## Verification
The properties are checked on every cycle. They cover the following:
- dma_start is a single-cycle pulse, and it only follows a second command word with bit 7 set.
- cmd_pending sets on a first word and clears on a second word or on a data-port access.
- The high address bits follow the second word.
- No stored register moves unless a register write event happened.

Only the bench's scenarios can show some other things. These are the exact merging of the two halves into acc_code and target_addr across a chain of commands, and the field layout of xfer_len and xfer_src. They also include the mode decode for each pattern of the top source bits, and the fact that unmapped indexes and a second word shaped like a register write leave every register alone.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

  localparam int WORD_W = 16;
  localparam int IDX_W  = 5;
  localparam int VAL_W  = 8;
  localparam int NREG   = 6;

  // Register slots, in the order the top module unpacks them.
  localparam logic [IDX_W-1:0] REG_MAP [NREG] = '{
    5'h0F, 5'h13, 5'h14, 5'h15, 5'h16, 5'h17
  };

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_REG  = 2'd1,
    WK_CMD1 = 2'd2,
    WK_CMD2 = 2'd3
  } word_kind_e;

  // Sort one control-port word, given the command state.
  function automatic word_kind_e classify(input logic wr, input logic pending,
                                          input logic [1:0] top);
    if (!wr)                 return WK_NONE;
    else if (pending)        return WK_CMD2;
    else if (top == 2'b10)   return WK_REG;
    else                     return WK_CMD1;
  endfunction

  // Mode from the top two bits of the high source register.
  function automatic logic [1:0] mode_of(input logic [1:0] hi_bits);
    return hi_bits[1] ? {1'b1, hi_bits[0]} : 2'b00;
  endfunction

endpackage

// File: rtl/vcp_word_classifier.sv
module vcp_word_classifier
  import vcp_pkg::*;
(
  input  logic       ctl_wr,
  input  logic       pending,
  input  logic [1:0] top_bits,
  output word_kind_e kind
);
  always_comb kind = classify(ctl_wr, pending, top_bits);
endmodule

// File: rtl/vcp_reg_file.sv
module vcp_reg_file
  import vcp_pkg::*;
#(
  parameter int N   = NREG,
  parameter int IW  = IDX_W,
  parameter int VW  = VAL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         idx,
  input  logic [VW-1:0]         val,
  output logic [N-1:0][VW-1:0]  q
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    localparam logic [IW-1:0] SLOT_IDX = IW'(REG_MAP[g]);
    always_ff @(posedge clk) begin
      if (!rst_n)                          q[g] <= '0;
      else if (wr_en && idx == SLOT_IDX)   q[g] <= val;
    end
  end
endmodule

// File: rtl/vcp_cmd_latch.sv
module vcp_cmd_latch
  import vcp_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  word_kind_e    kind,
  input  logic [WW-1:0] word,
  input  logic          dat_acc,
  output logic          pending,
  output logic [5:0]    code,
  output logic [15:0]   addr,
  output logic          start
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      code    <= '0;
      addr    <= '0;
      start   <= 1'b0;
    end else begin
      start <= (kind == WK_CMD2) && word[7];
      if (kind == WK_CMD1) begin
        code[1:0]  <= word[15:14];
        addr[13:0] <= word[13:0];
      end else if (kind == WK_CMD2) begin
        code[5:2]   <= word[7:4];
        addr[15:14] <= word[1:0];
      end
      if (dat_acc)                pending <= 1'b0;
      else if (kind == WK_CMD1)   pending <= 1'b1;
      else if (kind == WK_CMD2)   pending <= 1'b0;
    end
  end
endmodule

// File: rtl/vcp_cmd_decoder.sv
module vcp_cmd_decoder
  import vcp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [15:0] ctl_data,
  input  logic        dat_acc,
  output logic        cmd_pending,
  output logic [5:0]  acc_code,
  output logic [15:0] target_addr,
  output logic        dma_start,
  output logic [7:0]  addr_step,
  output logic [15:0] xfer_len,
  output logic [22:0] xfer_src,
  output logic [1:0]  xfer_mode
);
  word_kind_e                  kind;
  logic [NREG-1:0][VAL_W-1:0]  regs;

  // Named events for the checker.
  logic ev_reg_wr, ev_cmd1, ev_cmd2;
  assign ev_reg_wr = (kind == WK_REG);
  assign ev_cmd1   = (kind == WK_CMD1);
  assign ev_cmd2   = (kind == WK_CMD2);

  vcp_word_classifier u_cls (
    .ctl_wr   (ctl_wr),
    .pending  (cmd_pending),
    .top_bits (ctl_data[15:14]),
    .kind     (kind)
  );

  vcp_reg_file u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ev_reg_wr),
    .idx   (ctl_data[12:8]),
    .val   (ctl_data[7:0]),
    .q     (regs)
  );

  vcp_cmd_latch u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .word    (ctl_data),
    .dat_acc (dat_acc),
    .pending (cmd_pending),
    .code    (acc_code),
    .addr    (target_addr),
    .start   (dma_start)
  );

  assign addr_step = regs[0];
  assign xfer_len  = {regs[2], regs[1]};
  assign xfer_src  = {regs[5][6:0], regs[4], regs[3]};
  assign xfer_mode = mode_of(regs[5][7:6]);
endmodule

// File: rtl/vcp_cmd_decoder_chk.sv
module vcp_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic [15:0] ctl_data,
  input logic        dat_acc,
  input logic        cmd_pending,
  input logic [15:0] target_addr,
  input logic        dma_start,
  input logic [7:0]  addr_step,
  input logic [15:0] xfer_len,
  input logic [22:0] xfer_src,
  input logic        ev_reg_wr,
  input logic        ev_cmd1,
  input logic        ev_cmd2
);
  p_start_one_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  p_start_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> $past(ev_cmd2 && ctl_data[7]));

  p_first_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !cmd_pending && ctl_data[15:14] != 2'b10 && !dat_acc) |=> cmd_pending);

  p_second_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && cmd_pending) |=> !cmd_pending);

  p_addr_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd2 |=> target_addr[15:14] == $past(ctl_data[1:0]));

  p_data_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_acc |=> !cmd_pending);

  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_reg_wr |=> ($stable(addr_step) && $stable(xfer_len) && $stable(xfer_src)));

  p_low_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cmd1 |=> $stable(target_addr[13:0]));
endmodule

bind vcp_cmd_decoder vcp_cmd_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
  .dat_acc(dat_acc), .cmd_pending(cmd_pending), .target_addr(target_addr),
  .dma_start(dma_start), .addr_step(addr_step), .xfer_len(xfer_len),
  .xfer_src(xfer_src), .ev_reg_wr(ev_reg_wr), .ev_cmd1(ev_cmd1),
  .ev_cmd2(ev_cmd2)
);

// File: tb/vcp_cmd_decoder_tb_top.sv
module vcp_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_data = '0;
  logic        dat_acc = 1'b0;
  logic        cmd_pending, dma_start;
  logic [5:0]  acc_code;
  logic [15:0] target_addr, xfer_len;
  logic [7:0]  addr_step;
  logic [22:0] xfer_src;
  logic [1:0]  xfer_mode;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vcp_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .dat_acc(dat_acc), .cmd_pending(cmd_pending), .acc_code(acc_code),
    .target_addr(target_addr), .dma_start(dma_start), .addr_step(addr_step),
    .xfer_len(xfer_len), .xfer_src(xfer_src), .xfer_mode(xfer_mode)
  );

  // {data_access, word, exp_pending, exp_code, exp_addr, exp_start}
  localparam int NV = 13;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 16'h4000, 1'b1, 6'h01, 16'h0000, 1'b0},
    {1'b0, 16'h0080, 1'b0, 6'h21, 16'h0000, 1'b1},
    {1'b0, 16'hC012, 1'b1, 6'h23, 16'h0012, 1'b0},
    {1'b0, 16'h0000, 1'b0, 6'h03, 16'h0012, 1'b0},
    {1'b0, 16'h7ABC, 1'b1, 6'h01, 16'h3ABC, 1'b0},
    {1'b0, 16'h0093, 1'b0, 6'h25, 16'hFABC, 1'b1},
    {1'b0, 16'h0001, 1'b1, 6'h24, 16'hC001, 1'b0},
    {1'b1, 16'h0000, 1'b0, 6'h24, 16'hC001, 1'b0},
    {1'b0, 16'h8F02, 1'b0, 6'h24, 16'hC001, 1'b0},
    {1'b0, 16'h0000, 1'b1, 6'h24, 16'hC000, 1'b0},
    {1'b0, 16'h8F42, 1'b0, 6'h10, 16'h8000, 1'b0},
    {1'b0, 16'h00C1, 1'b1, 6'h10, 16'h80C1, 1'b0},
    {1'b0, 16'h00C0, 1'b0, 6'h30, 16'h00C1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [15:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_data = w;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic dacc();
    @(negedge clk); dat_acc = 1'b1;
    @(negedge clk); dat_acc = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 pending", 32'(cmd_pending), 0);
    chk("R1 start", 32'(dma_start), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code", 32'(acc_code), 0);
    chk("R1 addr", 32'(target_addr), 0);
    chk("R1 regs", 32'({addr_step, xfer_len}), 0);
    chk("R1 src", 32'({xfer_mode, xfer_src}), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) dacc(); else ctl(VEC[i][39:24]);
      chk("R4/R5/R8 pending", 32'(cmd_pending), 32'(VEC[i][23]));
      chk("R4/R5 code", 32'(acc_code), 32'(VEC[i][22:17]));
      chk("R4/R5 addr", 32'(target_addr), 32'(VEC[i][16:1]));
      chk("R6 start", 32'(dma_start), 32'(VEC[i][0]));
      if (VEC[i][0]) begin
        @(negedge clk);
        chk("R6 single pulse", 32'(dma_start), 0);
      end
      if (i == 8)  chk("R10 step after reg write", 32'(addr_step), 32'h02);
      if (i == 10) chk("R5 second word writes no reg", 32'(addr_step), 32'h02);
    end

    // R2/R9: length and source fields
    ctl(16'h9334); ctl(16'h9412);
    chk("R9 length", 32'(xfer_len), 32'h1234);
    ctl(16'h9556); ctl(16'h9678); ctl(16'h979A);
    chk("R9 source", 32'(xfer_src), 32'h1A7856);
    chk("R7 fill mode", 32'(xfer_mode), 32'h2);
    ctl(16'h97C0);
    chk("R7 copy mode", 32'(xfer_mode), 32'h3);
    chk("R9 source hi", 32'(xfer_src), 32'h407856);
    ctl(16'h9740);
    chk("R7 host mode bit6", 32'(xfer_mode), 32'h0);
    ctl(16'h9700);
    chk("R7 host mode", 32'(xfer_mode), 32'h0);
    ctl(16'h8F01);
    chk("R2 step", 32'(addr_step), 32'h01);

    // R3: unmapped indexes change nothing
    ctl(16'h8155); ctl(16'h9F55); ctl(16'h8E55);
    chk("R3 step", 32'(addr_step), 32'h01);
    chk("R3 length", 32'(xfer_len), 32'h1234);
    chk("R3 source", 32'(xfer_src), 32'h007856);
    chk("R3 pending", 32'(cmd_pending), 0);
    chk("R3 code/addr", 32'({acc_code, target_addr}), 32'({6'h30, 16'h00C1}));

    // R8: abandoned command, then a register write is honoured
    ctl(16'h4123);
    chk("R4 pending", 32'(cmd_pending), 1);
    dacc();
    chk("R8 cleared", 32'(cmd_pending), 0);
    ctl(16'h8F07);
    chk("R8 next word is reg write", 32'(addr_step), 32'h07);
    chk("R8 no second word", 32'(acc_code), 32'h31);

    // R1: reset mid-command
    ctl(16'h4000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset pending", 32'(cmd_pending), 0);
    chk("R1 reset regs", 32'({addr_step, xfer_len}), 0);
    rst_n = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule